// File: doc/BRIEF.md
# DSP Host Port Bus Master

This block is a synchronous bus master that carries single-byte read and write requests from on-chip logic onto an 8-bit host-port style bus facing a DSP. The requester raises a request with an address, a direction and write data. The master then runs one external cycle in five fixed phases: address, setup, strobe, hold and recovery. It drives chip select, address, a data strobe, a read/not-write line and a tristate-controlled data bus.

The length of every phase comes from a small configuration field. A field value of N gives N+1 bus clocks. The block raises the address, setup and strobe fields to their safe minimums if they are programmed lower. It copies all fields when it accepts a request, so a change made later in that cycle has no effect.

The DSP can hold off the master with a wait input, and this input only matters during the address and strobe phases. The master reports completion with a one-clock done pulse at the end of the hold phase. For a read, the captured byte is presented with that pulse.

Top module: `dsp_port_master`

## Requirements
- R1: Each access runs address, setup, strobe, hold, recovery in that order. Chip select (active low) and the access address are applied in the same first address-phase clock. Chip select stays low through hold and is high in recovery and idle. The address is stable while chip select is low.
- R2: A phase whose latched field is N lasts N+1 clocks. The address, setup and strobe fields are 2 bits wide, the hold field is 2 bits wide and the recovery field is 4 bits wide.
- R3: Address and setup fields below 2 are treated as 2, and a strobe field below 1 is treated as 1. An all-zero setting therefore gives 3, 3 and 2 clocks for those phases.
- R4: The data strobe (active low) is low only during the strobe phase. Its width equals the strobe phase length, including any wait extension.
- R5: bus_wait_i (high means wait) reaches the sequencer through a two-flop synchronizer. While the synchronized wait is high in the address or strobe phase, that phase does not advance. After the wait clears, the phase lasts one more clock before its count resumes. Wait is ignored in the setup, hold and recovery phases.
- R6: With the request held, chip select stays high for recovery length + 1 clocks between two accesses: the recovery phase plus one idle clock. No address phase starts before recovery ends.
- R7: Configuration fields are latched when a request is accepted. Changing them during an access does not alter that access.
- R8: For a write, bus_rnw_o is 0, and bus_data_oe_o is high exactly during the setup, strobe and hold phases with bus_data_o equal to the write data. For a read, bus_rnw_o is 1 and bus_data_oe_o stays 0.
- R9: For a read, bus_data_i is sampled on the last strobe clock and appears on rdata_o by the done pulse.
- R10: done_o is a single-clock pulse on the last hold clock. A request is only accepted in idle. After reset, chip select and strobe are high, and output enable and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request, held until done_o |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Access address |
| wdata_i | input | DATA_W | Write data |
| cfg_addr_i | input | PH_W | Address phase field |
| cfg_setup_i | input | PH_W | Setup phase field |
| cfg_strobe_i | input | PH_W | Strobe phase field |
| cfg_hold_i | input | PH_W | Hold phase field |
| cfg_recov_i | input | REC_W | Recovery phase field |
| done_o | output | 1 | One-clock completion pulse |
| rdata_o | output | DATA_W | Captured read data |
| bus_addr_o | output | ADDR_W | External address |
| bus_cs_no | output | 1 | Chip select, active low |
| bus_ds_no | output | 1 | Data strobe, active low |
| bus_rnw_o | output | 1 | 1 = read, 0 = write |
| bus_data_o | output | DATA_W | Write data to the bus |
| bus_data_oe_o | output | 1 | Data bus output enable |
| bus_data_i | input | DATA_W | Read data from the bus |
| bus_wait_i | input | 1 | DSP wait request, high = hold |

## Verification
A wrong phase count or a bad phase transition shows directly at the bus pins. It moves the chip-select low time, the clock on which the strobe falls, the strobe width or the output-enable window, and all of these are measured in whole clocks within the same access. A mistake in wait handling shifts the strobe or address-phase length by the missing or extra clocks. Capture taken on the wrong strobe clock returns a different byte, because the bench drives a new byte on every strobe clock. A configuration that is not frozen, or a recovery phase that is too short, shows up in the same access or in the gap before the next chip select.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_ADDR  = 3'd1,
    PH_SETUP = 3'd2,
    PH_STRB  = 3'd3,
    PH_HOLD  = 3'd4,
    PH_RECOV = 3'd5
  } phase_e;
endpackage

// File: rtl/dpm_sync.sv
module dpm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], d_i};
  end

  assign q_o = sync_q[STAGES-1];
endmodule

// File: rtl/dpm_cfg.sv
module dpm_cfg #(
  parameter int unsigned PH_W      = 2,
  parameter int unsigned REC_W     = 4,
  parameter int unsigned ADDR_MIN  = 2,
  parameter int unsigned SETUP_MIN = 2,
  parameter int unsigned STRB_MIN  = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [PH_W-1:0]  addr_i,
  input  logic [PH_W-1:0]  setup_i,
  input  logic [PH_W-1:0]  strobe_i,
  input  logic [PH_W-1:0]  hold_i,
  input  logic [REC_W-1:0] recov_i,
  output logic [PH_W-1:0]  addr_o,
  output logic [PH_W-1:0]  setup_o,
  output logic [PH_W-1:0]  strobe_o,
  output logic [PH_W-1:0]  hold_o,
  output logic [REC_W-1:0] recov_o
);
  localparam logic [PH_W-1:0] AMIN = PH_W'(ADDR_MIN);
  localparam logic [PH_W-1:0] SMIN = PH_W'(SETUP_MIN);
  localparam logic [PH_W-1:0] TMIN = PH_W'(STRB_MIN);

  logic [PH_W-1:0] addr_c, setup_c, strobe_c;

  // raise illegal short settings to the safe floor
  assign addr_c   = (addr_i   < AMIN) ? AMIN : addr_i;
  assign setup_c  = (setup_i  < SMIN) ? SMIN : setup_i;
  assign strobe_c = (strobe_i < TMIN) ? TMIN : strobe_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o   <= AMIN;
      setup_o  <= SMIN;
      strobe_o <= TMIN;
      hold_o   <= '0;
      recov_o  <= '0;
    end else if (load_i) begin
      addr_o   <= addr_c;
      setup_o  <= setup_c;
      strobe_o <= strobe_c;
      hold_o   <= hold_i;
      recov_o  <= recov_i;
    end
  end
endmodule

// File: rtl/dpm_seq.sv
module dpm_seq
  import dpm_pkg::*;
#(
  parameter int unsigned PH_W  = 2,
  parameter int unsigned REC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wait_i,
  input  logic [PH_W-1:0]  t_addr_i,
  input  logic [PH_W-1:0]  t_setup_i,
  input  logic [PH_W-1:0]  t_strobe_i,
  input  logic [PH_W-1:0]  t_hold_i,
  input  logic [REC_W-1:0] t_recov_i,
  output phase_e           phase_o,
  output logic             accept_o,
  output logic             strb_end_o,
  output logic             hold_end_o
);
  localparam int unsigned CW = (REC_W > PH_W) ? REC_W : PH_W;

  phase_e          phase_q, phase_nxt;
  logic [CW-1:0]   cnt_q, lim;
  logic            stretch_q, holdable, freeze, at_lim;

  always_comb begin
    lim       = '0;
    phase_nxt = PH_IDLE;
    case (phase_q)
      PH_ADDR:  begin lim = CW'(t_addr_i);   phase_nxt = PH_SETUP; end
      PH_SETUP: begin lim = CW'(t_setup_i);  phase_nxt = PH_STRB;  end
      PH_STRB:  begin lim = CW'(t_strobe_i); phase_nxt = PH_HOLD;  end
      PH_HOLD:  begin lim = CW'(t_hold_i);   phase_nxt = PH_RECOV; end
      PH_RECOV: begin lim = CW'(t_recov_i);  phase_nxt = PH_IDLE;  end
      default:  begin lim = '0;              phase_nxt = PH_IDLE;  end
    endcase
  end

  assign holdable = (phase_q == PH_ADDR) || (phase_q == PH_STRB);
  assign freeze   = holdable && wait_i;
  assign at_lim   = (cnt_q == lim) && !freeze && !stretch_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      cnt_q     <= '0;
      stretch_q <= 1'b0;
    end else if (phase_q == PH_IDLE) begin
      if (req_i) begin
        phase_q <= PH_ADDR;
        cnt_q   <= '0;
      end
    end else if (freeze) begin
      stretch_q <= 1'b1;
    end else if (stretch_q) begin
      stretch_q <= 1'b0;     // one guaranteed clock after wait clears
    end else if (cnt_q == lim) begin
      phase_q <= phase_nxt;
      cnt_q   <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign phase_o    = phase_q;
  assign accept_o   = (phase_q == PH_IDLE) && req_i;
  assign strb_end_o = (phase_q == PH_STRB) && at_lim;
  assign hold_end_o = (phase_q == PH_HOLD) && at_lim;

  AST_WAIT_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    freeze |=> (phase_q == $past(phase_q))); // R5
  AST_WAIT_EXTRA_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(wait_i) && !wait_i && holdable && ($past(phase_q) == phase_q))
      |=> (phase_q == $past(phase_q))); // R5
  AST_ADDR_FROM_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((phase_q == PH_ADDR) && ($past(phase_q) != PH_ADDR)) |-> ($past(phase_q) == PH_IDLE)); // R6
  AST_STRB_TO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (($past(phase_q) == PH_STRB) && (phase_q != PH_STRB)) |-> (phase_q == PH_HOLD)); // R1
endmodule

// File: rtl/dsp_port_master.sv
module dsp_port_master
  import dpm_pkg::*;
#(
  parameter int unsigned ADDR_W      = 3,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned PH_W        = 2,
  parameter int unsigned REC_W       = 4,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned ADDR_MIN    = 2,
  parameter int unsigned SETUP_MIN   = 2,
  parameter int unsigned STRB_MIN    = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [PH_W-1:0]   cfg_addr_i,
  input  logic [PH_W-1:0]   cfg_setup_i,
  input  logic [PH_W-1:0]   cfg_strobe_i,
  input  logic [PH_W-1:0]   cfg_hold_i,
  input  logic [REC_W-1:0]  cfg_recov_i,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_cs_no,
  output logic              bus_ds_no,
  output logic              bus_rnw_o,
  output logic [DATA_W-1:0] bus_data_o,
  output logic              bus_data_oe_o,
  input  logic [DATA_W-1:0] bus_data_i,
  input  logic              bus_wait_i
);
  phase_e             phase;
  logic               accept, strb_end, hold_end, wait_s;
  logic [PH_W-1:0]    t_addr, t_setup, t_strobe, t_hold;
  logic [REC_W-1:0]   t_recov;
  logic [ADDR_W-1:0]  addr_q;
  logic [DATA_W-1:0]  wdata_q, rdata_q;
  logic               we_q;

  dpm_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i), .rst_ni (rst_ni), .d_i (bus_wait_i), .q_o (wait_s)
  );

  dpm_cfg #(
    .PH_W(PH_W), .REC_W(REC_W),
    .ADDR_MIN(ADDR_MIN), .SETUP_MIN(SETUP_MIN), .STRB_MIN(STRB_MIN)
  ) i_cfg (
    .clk_i (clk_i), .rst_ni (rst_ni), .load_i (accept),
    .addr_i (cfg_addr_i), .setup_i (cfg_setup_i), .strobe_i (cfg_strobe_i),
    .hold_i (cfg_hold_i), .recov_i (cfg_recov_i),
    .addr_o (t_addr), .setup_o (t_setup), .strobe_o (t_strobe),
    .hold_o (t_hold), .recov_o (t_recov)
  );

  dpm_seq #(.PH_W(PH_W), .REC_W(REC_W)) i_seq (
    .clk_i (clk_i), .rst_ni (rst_ni), .req_i (req_i), .wait_i (wait_s),
    .t_addr_i (t_addr), .t_setup_i (t_setup), .t_strobe_i (t_strobe),
    .t_hold_i (t_hold), .t_recov_i (t_recov),
    .phase_o (phase), .accept_o (accept),
    .strb_end_o (strb_end), .hold_end_o (hold_end)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q  <= '0;
      wdata_q <= '0;
      we_q    <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (accept) begin
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
        we_q    <= we_i;
      end
      if (strb_end && !we_q) rdata_q <= bus_data_i;
    end
  end

  assign bus_cs_no     = !(phase inside {PH_ADDR, PH_SETUP, PH_STRB, PH_HOLD});
  assign bus_ds_no     = (phase != PH_STRB);
  assign bus_rnw_o     = !we_q;
  assign bus_data_oe_o = we_q && (phase inside {PH_SETUP, PH_STRB, PH_HOLD});
  assign bus_data_o    = wdata_q;
  assign bus_addr_o    = addr_q;
  assign rdata_o       = rdata_q;
  assign done_o        = hold_end;

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R10
  AST_OE_WRITE_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_data_oe_o |-> !bus_rnw_o); // R8
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!bus_cs_no && $past(!bus_cs_no)) |-> $stable(bus_addr_o)); // R1
  AST_DONE_IN_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> bus_cs_no); // R10
endmodule

// File: tb/test_dsp_port_master.sv
`timescale 1ns/1ps
module test_dsp_port_master;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req = 1'b0, we = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [DATA_W-1:0] wdata = '0, bus_din = '0;
  logic [1:0]        c_addr = 2'd2, c_setup = 2'd2, c_strobe = 2'd1, c_hold = 2'd0;
  logic [3:0]        c_recov = 4'd0;
  logic              bus_wait = 1'b0;
  logic              done, cs_n, ds_n, rnw, oe;
  logic [DATA_W-1:0] rdata, bus_dout;
  logic [ADDR_W-1:0] bus_addr;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  dsp_port_master i_dsp_port_master (
    .clk_i (clk), .rst_ni (rst_n), .req_i (req), .we_i (we),
    .addr_i (addr), .wdata_i (wdata),
    .cfg_addr_i (c_addr), .cfg_setup_i (c_setup), .cfg_strobe_i (c_strobe),
    .cfg_hold_i (c_hold), .cfg_recov_i (c_recov),
    .done_o (done), .rdata_o (rdata), .bus_addr_o (bus_addr),
    .bus_cs_no (cs_n), .bus_ds_no (ds_n), .bus_rnw_o (rnw),
    .bus_data_o (bus_dout), .bus_data_oe_o (oe),
    .bus_data_i (bus_din), .bus_wait_i (bus_wait)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // one access; wait_at/wait_len index cycles from the first chip-select clock
  task automatic run_access(input logic w, input int a, input int wd,
                            input int t1, input int t2, input int t3, input int t4, input int t5,
                            input int wait_at, input int wait_len,
                            input int ext1, input int ext3, input bit poke);
    int idx, n_cs, n_ds, n_oe, first_ds, first_oe, done_idx, n_done, bad_wd, l1, l2, l3, l4;
    idx = 0; n_cs = 0; n_ds = 0; n_oe = 0; first_ds = -1; first_oe = -1;
    done_idx = -1; n_done = 0; bad_wd = 0;
    @(negedge clk);
    c_addr = 2'(t1); c_setup = 2'(t2); c_strobe = 2'(t3); c_hold = 2'(t4); c_recov = 4'(t5);
    we = w; addr = ADDR_W'(a); wdata = 8'(wd); req = 1'b1;
    while (cs_n) @(negedge clk);
    chk("R1 address with chip select", int'(bus_addr), a);
    chk("R8 read/write select", int'(rnw), int'(!w));
    while (!cs_n) begin
      if (idx == wait_at) bus_wait = 1'b1;
      if (idx == wait_at + wait_len) bus_wait = 1'b0;
      if (poke && idx == 1) begin
        c_addr = 2'd0; c_setup = 2'd3; c_strobe = 2'd0; c_hold = 2'd3; c_recov = 4'd15;
      end
      if (!ds_n) begin
        if (first_ds < 0) first_ds = idx;
        bus_din = 8'(8'hA0 + n_ds);
        n_ds++;
      end
      if (oe) begin
        if (first_oe < 0) first_oe = idx;
        n_oe++;
        if (bus_dout != 8'(wd)) bad_wd++;
      end
      if (done) begin
        done_idx = idx;
        n_done++;
        req = 1'b0;
      end
      n_cs++;
      idx++;
      @(negedge clk);
    end
    bus_wait = 1'b0;
    bus_din = '0;
    l1 = mx(t1, 2) + 1 + ext1;
    l2 = mx(t2, 2) + 1;
    l3 = mx(t3, 1) + 1 + ext3;
    l4 = t4 + 1;
    chk("R2 chip select low clocks", n_cs, l1 + l2 + l3 + l4);
    chk("R1 strobe start after address+setup", first_ds, l1 + l2);
    chk("R4 strobe width", n_ds, l3);
    chk("R10 done on last hold clock", done_idx, l1 + l2 + l3 + l4 - 1);
    chk("R10 single done pulse", n_done, 1);
    chk("R8 output enable clocks", n_oe, w ? (l2 + l3 + l4) : 0);
    if (w) begin
      chk("R8 output enable starts at setup", first_oe, l1);
      chk("R8 write data on bus", bad_wd, 0);
    end else begin
      chk("R9 read byte from last strobe clock", int'(rdata), (8'hA0 + l3 - 1) & 8'hFF);
    end
  endtask

  task automatic t_reset();
    chk("R10 reset chip select high", int'(cs_n), 1);
    chk("R10 reset strobe high", int'(ds_n), 1);
    chk("R10 reset output enable low", int'(oe), 0);
    chk("R10 reset done low", int'(done), 0);
  endtask

  task automatic t_write_basic();
    run_access(1'b1, 5, 8'h3C, 2, 2, 1, 0, 0, -10, 0, 0, 0, 1'b0);
  endtask

  task automatic t_read_long();
    run_access(1'b0, 2, 0, 3, 3, 3, 2, 5, -10, 0, 0, 0, 1'b0);
  endtask

  task automatic t_clamp();
    // R3: all-zero fields give 3,3,2,1 clocks
    run_access(1'b0, 7, 0, 0, 0, 0, 0, 0, -10, 0, 0, 0, 1'b0);
    run_access(1'b1, 1, 8'h81, 1, 1, 0, 1, 1, -10, 0, 0, 0, 1'b0);
  endtask

  task automatic t_wait_strobe();
    // R5/R4: wait during strobe adds wait clocks plus one
    run_access(1'b0, 3, 0, 2, 2, 3, 0, 0, 6, 2, 0, 3, 1'b0);
  endtask

  task automatic t_wait_addr();
    // R5: wait during address phase
    run_access(1'b1, 4, 8'h5A, 2, 2, 1, 1, 0, 0, 3, 4, 0, 1'b0);
  endtask

  task automatic t_wait_setup();
    // R5: wait confined to setup phase is ignored
    run_access(1'b1, 6, 8'hC3, 2, 3, 1, 1, 0, 3, 2, 0, 0, 1'b0);
  endtask

  task automatic t_cfg_frozen();
    // R7: fields changed mid-access are not used
    run_access(1'b1, 2, 8'h77, 3, 2, 2, 0, 0, -10, 0, 0, 0, 1'b1);
  endtask

  task automatic t_gap();
    int gap;
    run_access(1'b1, 1, 8'h11, 2, 2, 1, 0, 4, -10, 0, 0, 0, 1'b0);
    // now at the first recovery clock; hold request through recovery
    c_addr = 2'd2; c_setup = 2'd2; c_strobe = 2'd1; c_hold = 2'd0; c_recov = 4'd4;
    we = 1'b1; addr = 3'd6; wdata = 8'h22; req = 1'b1;
    gap = 0;
    while (cs_n) begin
      gap++;
      @(negedge clk);
    end
    chk("R6 recovery gap before next chip select", gap, 4 + 2);
    chk("R6 next access address", int'(bus_addr), 6);
    while (!done) @(negedge clk);
    req = 1'b0;
    while (!cs_n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL R10 watchdog: actual no finish expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_write_basic();
    t_read_long();
    t_clamp();
    t_wait_strobe();
    t_wait_addr();
    t_wait_setup();
    t_cfg_frozen();
    t_gap();
    repeat (20) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule